// File: doc/BRIEF.md
# PWM Generator with Buffered Register Updates

This block is one pulse-width generator built around a single counter. A load value sets the period. Two compare values set the duty cycles of two outputs. Both outputs are timed by the same counter. A small register port writes and reads four registers: one control word, the load value, and the two compare values.

Writes to the load and compare registers go into shadow copies. The counter and the outputs never see a shadow copy directly. A shadow copy is moved into the working copy only on a clock edge where the counter is at zero. Each of the three registers has its own update policy. Under one policy the move happens at every zero. Under the other it happens only at the first zero after a chip-wide synchronous-update pulse. This lets several generators switch to new settings on the same period boundary.

A debug-halt input can park the counter at zero, or the control word can let the counter run through debug.

Top module: `pwm_gen`

## Requirements
- R1: The register port has four addresses. Address 0 is the control word: bits 5:0 are read/write and bits 31:6 read as 0 whatever was written. Addresses 1, 2 and 3 hold the load value, compare A and compare B, each CNT_W bits wide and read back zero-extended. Reads of addresses 1 to 3 return the last value written, not the working copy. All four registers read 0 after reset.
- R2: Control bit 0 is the enable. While it is 0, the counter is 0, the direction is reset to upward, and both outputs are low.
- R3: When control bit 1 is 0 (down mode) and the block is enabled, a counter at zero reloads with the load value committed on that same edge. Any other value decrements by one. The period is load+1 cycles.
- R4: When control bit 1 is 1 (up/down mode) and the block is enabled, the counter climbs from 0 to the load value and then descends back to 0. The period is 2*load cycles, and a load of 0 keeps the counter at 0.
- R5: In down mode an output is high at counter 0 and while the counter is above its compare value. It is low when the counter equals the compare value, and equality takes precedence.
- R6: In up/down mode an output is high while the counter is at or below its compare value.
- R7: Control bits 3 (load), 4 (compare A) and 5 (compare B) select each register's update policy. When the policy bit is 0, the working copy takes the shadow value on every edge where the counter is 0. The shadow value used is the one held before that edge.
- R8: When the policy bit is 1, the commit happens only on a counter-zero edge while a sync request is already latched for that register. A sync pulse is latched on the edge where it is seen. The latch clears on a counter-zero edge. Extra pulses before that zero change nothing.
- R9: Control bit 2 selects debug behaviour. When it is 0 and debug-halt is high, a counter at zero stays at zero, and counting resumes once debug-halt falls. When it is 1, debug-halt is ignored.
- R10: The working load and compare values change only on edges where the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 control, 1 load, 2 compare A, 3 compare B) |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address, same map as writes |
| rdData | output | 32 | Combinational read data |
| syncReq | input | 1 | Chip-wide synchronous-update pulse |
| debugHalt | input | 1 | Debug mode request |
| pwmA | output | 1 | Output driven by compare A |
| pwmB | output | 1 | Output driven by compare B |
| count | output | CNT_W | Current counter value |

## Verification
Some properties are checked on every cycle by the assertions:
- a down-mode step is always a decrement by one;
- an up/down step always moves by exactly one;
- a disabled counter sits at zero;
- a halted counter stays parked at zero;
- a latched sync request always clears on a zero edge;
- the working load and compare values never move off a zero edge.

Other behaviours only the bench's scenarios can show. These include the exact waveform shapes, the read-back of shadow values against a stale working copy, and the choice between the two commit policies. They also include the case where a sync pulse is deferred until after a zero, and the point where a halted counter resumes. The bench's reference model tracks these cycle by cycle.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  // register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LOAD = 2'd1;

  // control word bit positions
  localparam int CTRL_W       = 6;
  localparam int BIT_ENABLE   = 0;
  localparam int BIT_UPDOWN   = 1;
  localparam int BIT_DBG_RUN  = 2;
  localparam int BIT_SYNC_LO  = 3;  // 3 load, 4 cmpA, 5 cmpB

  // control -> datapath strobes
  typedef struct packed {
    logic       enable;
    logic       upDown;
    logic       holdAtZero;
    logic       commitLoad;
    logic [1:0] commitCmp;
  } strobe_t;

endpackage

// File: rtl/pwm_gen_ctrl.sv
module pwm_gen_ctrl
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [REG_W-1:0] rdData,
  input  logic             syncReq,
  input  logic             debugHalt,
  input  logic             atZero,
  output strobe_t          strobe,
  output logic [CNT_W-1:0] shLoad,
  output logic [CNT_W-1:0] shCmpA,
  output logic [CNT_W-1:0] shCmpB
);
  localparam int NSH = 3;

  logic [CTRL_W-1:0] ctrlQ;
  logic [CNT_W-1:0]  shadowQ [NSH];
  logic              pendQ   [NSH];
  logic [NSH-1:0]    commit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ctrlQ <= '0;
    else if (wrEn && wrAddr == ADDR_CTRL) ctrlQ <= wrData[CTRL_W-1:0];
  end

  generate
    for (genvar i = 0; i < NSH; i++) begin : g_shadow
      localparam logic [1:0] MY_ADDR = 2'(i + 1);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          shadowQ[i] <= '0;
          pendQ[i]   <= 1'b0;
        end else begin
          if (wrEn && wrAddr == MY_ADDR) shadowQ[i] <= wrData[CNT_W-1:0];
          pendQ[i] <= syncReq | (pendQ[i] & ~atZero);
        end
      end

      assign commit[i] = atZero & (ctrlQ[BIT_SYNC_LO+i] ? pendQ[i] : 1'b1);

      // R8: a latched request is consumed by the next zero edge
      assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
        pendQ[i] && atZero && !syncReq |=> !pendQ[i]);
    end

    if (CNT_W < REG_W) begin : g_unused
      logic unusedWrHigh;
      assign unusedWrHigh = ^wrData[REG_W-1:CNT_W];
    end
  endgenerate

  assign strobe.enable     = ctrlQ[BIT_ENABLE];
  assign strobe.upDown     = ctrlQ[BIT_UPDOWN];
  assign strobe.holdAtZero = debugHalt & ~ctrlQ[BIT_DBG_RUN];
  assign strobe.commitLoad = commit[0];
  assign strobe.commitCmp  = commit[2:1];

  assign shLoad = shadowQ[0];
  assign shCmpA = shadowQ[1];
  assign shCmpB = shadowQ[2];

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_CTRL) rdData[CTRL_W-1:0] = ctrlQ;
    else                     rdData[CNT_W-1:0]  = shadowQ[rdAddr - 2'd1];
  end

endmodule

// File: rtl/pwm_gen_datapath.sv
module pwm_gen_datapath
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [CNT_W-1:0] shLoad,
  input  logic [CNT_W-1:0] shCmpA,
  input  logic [CNT_W-1:0] shCmpB,
  output logic [CNT_W-1:0] count,
  output logic             atZero,
  output logic             pwmA,
  output logic             pwmB
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] cntQ, cntNext, loadAct, loadNext;
  logic             dirUpQ, dirNext;
  logic [CNT_W-1:0] cmpSh  [NCH];
  logic [CNT_W-1:0] cmpAct [NCH];
  logic [NCH-1:0]   pwmRaw;

  assign atZero   = (cntQ == '0);
  assign loadNext = strobe.commitLoad ? shLoad : loadAct;
  assign cmpSh[0] = shCmpA;
  assign cmpSh[1] = shCmpB;

  always_comb begin
    cntNext = cntQ;
    dirNext = dirUpQ;
    if (!strobe.enable) begin
      cntNext = '0;
      dirNext = 1'b1;
    end else if (atZero && strobe.holdAtZero) begin
      cntNext = cntQ;
    end else if (!strobe.upDown) begin
      cntNext = atZero ? loadNext : cntQ - 1'b1;
    end else if (atZero) begin
      dirNext = 1'b1;
      cntNext = (loadNext == '0) ? '0 : CNT_W'(1);
    end else if (dirUpQ && cntQ < loadAct) begin
      cntNext = cntQ + 1'b1;
    end else begin
      dirNext = 1'b0;
      cntNext = cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      dirUpQ  <= 1'b1;
      loadAct <= '0;
    end else begin
      cntQ    <= cntNext;
      dirUpQ  <= dirNext;
      loadAct <= loadNext;
    end
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chan
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    cmpAct[i] <= '0;
        else if (strobe.commitCmp[i]) cmpAct[i] <= cmpSh[i];
      end

      assign pwmRaw[i] = strobe.enable &
        (strobe.upDown ? (cntQ <= cmpAct[i])
                       : ((cntQ != cmpAct[i]) && (atZero || cntQ > cmpAct[i])));

      // R10: compare working copy moves only at a zero edge
      assert_cmp_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
        !atZero |=> $stable(cmpAct[i]));
    end
  endgenerate

  assign count = cntQ;
  assign pwmA  = pwmRaw[0];
  assign pwmB  = pwmRaw[1];

  assert_disabled_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enable |=> cntQ == '0);

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enable && !strobe.upDown && cntQ != '0 |=> cntQ == $past(cntQ) - 1'b1);

  assert_updown_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enable && strobe.upDown && cntQ != '0
      |=> (cntQ == $past(cntQ) + 1'b1) || (cntQ == $past(cntQ) - 1'b1));

  assert_halt_park_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enable && strobe.holdAtZero && cntQ == '0 |=> cntQ == '0);

  assert_load_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !atZero |=> $stable(loadAct));

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [REG_W-1:0] rdData,
  input  logic             syncReq,
  input  logic             debugHalt,
  output logic             pwmA,
  output logic             pwmB,
  output logic [CNT_W-1:0] count
);
  strobe_t          strobe;
  logic             atZero;
  logic [CNT_W-1:0] shLoad, shCmpA, shCmpB;

  pwm_gen_ctrl #(.CNT_W(CNT_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .syncReq(syncReq), .debugHalt(debugHalt),
    .atZero(atZero), .strobe(strobe), .shLoad(shLoad), .shCmpA(shCmpA),
    .shCmpB(shCmpB)
  );

  pwm_gen_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shLoad(shLoad), .shCmpA(shCmpA),
    .shCmpB(shCmpB), .count(count), .atZero(atZero), .pwmA(pwmA), .pwmB(pwmB)
  );

endmodule

// File: tb/tb_pwm_gen.sv
module tb_pwm_gen;
  localparam int CNT_W = 16;
  localparam int MASK  = (1 << CNT_W) - 1;

  logic             clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0]       wrAddr = '0, rdAddr = '0;
  logic [31:0]      wrData = '0;
  logic             syncReq = 1'b0, debugHalt = 1'b0;
  wire  [31:0]      rdData;
  wire              pwmA, pwmB;
  wire  [CNT_W-1:0] count;

  pwm_gen #(.CNT_W(CNT_W), .REG_W(32)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .syncReq(syncReq), .debugHalt(debugHalt),
    .pwmA(pwmA), .pwmB(pwmB), .count(count)
  );

  always #4 clk = ~clk;  // 125 MHz

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  // behavioural reference model
  int mCtrl = 0, mCnt = 0, mUp = 1;
  int mSh[3]   = '{0, 0, 0};
  int mAct[3]  = '{0, 0, 0};
  int mPend[3] = '{0, 0, 0};

  function automatic int expPwm(int cmp);
    if ((mCtrl & 1) == 0) return 0;
    if (mCtrl & 2) return (mCnt <= cmp) ? 1 : 0;
    return (mCnt != cmp && (mCnt == 0 || mCnt > cmp)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      automatic int zero = (mCnt == 0);
      automatic int c[3];
      automatic int ldEff;
      for (int i = 0; i < 3; i++)
        c[i] = zero && (((mCtrl >> (3 + i)) & 1) ? mPend[i] : 1);
      ldEff = c[0] ? mSh[0] : mAct[0];
      if ((mCtrl & 1) == 0) begin
        mCnt = 0; mUp = 1;
      end else if (zero && debugHalt && !(mCtrl & 4)) begin
        mCnt = mCnt;
      end else if ((mCtrl & 2) == 0) begin
        mCnt = zero ? ldEff : mCnt - 1;
      end else if (zero) begin
        mUp = 1; mCnt = (ldEff == 0) ? 0 : 1;
      end else if (mUp && mCnt < mAct[0]) begin
        mCnt = mCnt + 1;
      end else begin
        mUp = 0; mCnt = mCnt - 1;
      end
      for (int i = 0; i < 3; i++) begin
        if (c[i]) mAct[i] = mSh[i];
        mPend[i] = (syncReq || (mPend[i] && !zero)) ? 1 : 0;
      end
      if (wrEn) begin
        if (wrAddr == 0) mCtrl = wrData & 63;
        else             mSh[wrAddr-1] = wrData & MASK;
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      automatic string cr = ((mCtrl & 1) == 0) ? "R2" : ((mCtrl & 2) ? "R4" : "R3");
      automatic string pr = ((mCtrl & 1) == 0) ? "R2" : ((mCtrl & 2) ? "R6" : "R5");
      check({cr, "/", tag}, int'(count), mCnt, "count");
      check({pr, "/", tag}, int'(pwmA), expPwm(mAct[1]), "pwmA");
      check({pr, "/", tag}, int'(pwmB), expPwm(mAct[2]), "pwmB");
    end
  end

  task automatic wr(int addr, int data);
    @(posedge clk); #2;
    wrEn = 1'b1; wrAddr = 2'(addr); wrData = 32'(data);
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic pulseSync();
    @(posedge clk); #2; syncReq = 1'b1;
    @(posedge clk); #2; syncReq = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rdCheck(int addr);
    automatic int exp;
    @(negedge clk); #1;
    rdAddr = 2'(addr); #1;
    exp = (addr == 0) ? mCtrl : mSh[addr-1];
    check("R1", int'(rdData), exp, "read");
  endtask

  initial begin
    #22 rstN = 1'b1;
    // R1: reset values
    for (int a = 0; a < 4; a++) rdCheck(a);
    tag = "R2"; idle(3);
    // down mode, immediate updates
    tag = "R7";
    wr(1, 5); wr(2, 2); wr(3, 4); wr(0, 1);
    idle(20);
    wr(2, 3);                         // R7: shadow visible, active waits for zero
    rdCheck(2);
    idle(20);
    // R1: reserved bits read 0
    wr(0, 32'hFFFF_FFC1);
    rdCheck(0);
    wr(3, 32'hABCD_0009);
    rdCheck(3);
    idle(15);
    // R8: sync policy
    tag = "R8";
    wr(0, 32'h39);
    wr(1, 7); wr(2, 1);
    idle(20);
    rdCheck(1);
    pulseSync(); pulseSync();
    idle(25);
    wr(3, 6);
    idle(12);
    pulseSync();
    idle(20);
    // up/down mode
    tag = "R10";
    wr(0, 3); wr(1, 6); wr(2, 2); wr(3, 5);
    idle(30);
    wr(1, 4);
    idle(20);
    // R9: debug halt at zero, then resume
    tag = "R9";
    debugHalt = 1'b1;
    idle(25);
    debugHalt = 1'b0;
    idle(15);
    wr(0, 7);
    debugHalt = 1'b1;
    idle(20);
    debugHalt = 1'b0;
    // load of zero corner
    tag = "R4";
    wr(1, 0); idle(12);
    wr(0, 1); idle(8);
    tag = "R3";
    wr(1, 3); wr(2, 0); idle(12);
    // disable
    tag = "R2";
    wr(0, 0);
    idle(6);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule